// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Bank

This block drives a set of pulse-width modulated outputs from a single shared period counter. An input-clock divider, set by a 4-bit prescale field, produces one local tick every (prescale + 1) input clocks. An 8-bit counter advances on each local tick, so one period always spans 256 local ticks. The period length can only be changed through the prescale value. Each channel compares the counter against its own duty value. A channel is high while the count is at or below that value, which gives a high time of duty + 1 local ticks. A duty of zero therefore still gives a one-tick pulse, and the top value holds the line high for the whole period.

Software reaches the block through a plain 32-bit register bus with separate write and read strobes and a byte address. Only address bits [AW-1:2] are decoded. The bus gives access to one duty register per channel, a control word holding the prescale and a run bit, a stored interrupt-enable bit, and a read-only view of the live counter. While the block runs, duty and prescale writes are held in a staging copy and move into the active copy only when the counter wraps. While the block is stopped, all outputs sit low, the counter and the divider sit at zero, and the staging copy passes straight through to the active copy.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, the counter reads 0, and every register reads 0.
- R2: While the block runs with active prescale P, the counter holds for P+1 input clocks per step and counts 0, 1, … 255 before returning to 0. One period is therefore 256·(P+1) input clocks.
- R3: With an active duty value N, a channel is high exactly while the counter is at most N. This gives N+1 local ticks high per period, and every channel is high at count 0.
- R4: A channel whose active duty is 255 stays high for the whole period.
- R5: When the run bit is cleared, all outputs go low in the following cycle. On the next edge the counter and the divider return to 0, and they stay there while the block is stopped.
- R6: While the block runs, new duty and prescale values take effect only at the edge where the counter wraps from 255 to 0. A write landing on that same edge is used at once. While the block is stopped, writes take effect on the next edge.
- R7: Register map by byte address. Channel n's duty is at 4·n in bits [7:0]. The control word at 0x50 holds the prescale in bits [3:0] and the run bit in bit 9. The interrupt enable is bit 0 of 0x54. Written values read back with all other bits as 0.
- R8: The counter reads at 0x60 in bits [7:0]. Writes to 0x60 change nothing.
- R9: Any other address, including duty slots at or beyond the channel count, reads 0, and writing to it changes no register or output.
- R10: The read data bus is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rd | input | 1 | Read strobe, read data is combinational |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pwm_out | output | NCH (4) | Channel outputs |

## Verification
The hardest case to reach from the ports is a duty write that lands on the same edge as the counter wrap. On that edge the staged value must be taken into the active copy at once rather than one period later. The bench gets there by setting the prescale to zero and polling the counter readback until it shows 255. It then drives the duty write in that same cycle, so the write and the wrap share one clock edge. A behavioural model, updated every clock, checks each output and every read against this ordering. It also covers prescale changes in mid-period and restarts from the stopped state.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // Word indices (byte address / 4) of the fixed registers.
  localparam int unsigned CTRL_WORD = 20;  // byte 0x50
  localparam int unsigned IRQ_WORD  = 21;  // byte 0x54
  localparam int unsigned CNT_WORD  = 24;  // byte 0x60

  // Field positions inside the fixed registers.
  localparam int unsigned RUN_BIT = 9;
  localparam int unsigned IRQ_BIT = 0;

  // Largest channel count that keeps duty slots clear of the control word.
  localparam int unsigned MAX_CHANNELS = CTRL_WORD;

endpackage

// File: rtl/pwm_bank_divider.sv
module pwm_bank_divider #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [PW-1:0] pre_nxt,
  output logic          tick
);

  logic [PW-1:0] div_q;
  logic [PW-1:0] lim_q;
  logic          at_limit;

  function automatic logic [PW-1:0] step_div(input logic [PW-1:0] cur,
                                             input logic          wrap_now);
    return wrap_now ? '0 : cur + 1'b1;
  endfunction

  assign at_limit = (div_q == lim_q);
  assign tick     = run && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lim_q <= '0;
    end else begin
      if (load) lim_q <= pre_nxt;
      if (!run) div_q <= '0;
      else      div_q <= step_div(div_q, at_limit);
    end
  end

endmodule

// File: rtl/pwm_bank_counter.sv
module pwm_bank_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] duty_nxt,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] act_duty,
  output logic          out
);

  logic [CW-1:0] act_q;

  function automatic logic in_high_window(input logic [CW-1:0] c,
                                          input logic [CW-1:0] d);
    return c <= d;
  endfunction

  assign act_duty = act_q;
  assign out      = run && in_high_window(cnt, act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= duty_nxt;
  end

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int PW  = 4,
  parameter int AW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  input  logic [CW-1:0]           cnt,
  output logic [31:0]             rdata,
  output logic [NCH-1:0][CW-1:0]  duty_nxt,
  output logic [PW-1:0]           pre_nxt,
  output logic                    run
);

  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_CTRL = WW'(CTRL_WORD);
  localparam logic [WW-1:0] W_IRQ  = WW'(IRQ_WORD);
  localparam logic [WW-1:0] W_CNT  = WW'(CNT_WORD);

  logic [WW-1:0]          word;
  logic [NCH-1:0][CW-1:0] duty_q;
  logic [PW-1:0]          pre_q;
  logic                   run_q, run_n;
  logic                   irq_q, irq_n;
  logic [31:0]            rd_val;
  logic                   unused_bits;

  assign word        = addr[AW-1:2];
  assign unused_bits = ^{addr[1:0], wdata};

  // Next state of the staged registers, also used by the active copies.
  always_comb begin
    duty_nxt = duty_q;
    pre_nxt  = pre_q;
    run_n    = run_q;
    irq_n    = irq_q;
    if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (word == WW'(i)) duty_nxt[i] = wdata[CW-1:0];
      end
      if (word == W_CTRL) begin
        pre_nxt = wdata[PW-1:0];
        run_n   = wdata[RUN_BIT];
      end
      if (word == W_IRQ) irq_n = wdata[IRQ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      pre_q  <= '0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      duty_q <= duty_nxt;
      pre_q  <= pre_nxt;
      run_q  <= run_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCH; i++) begin
      if (word == WW'(i)) rd_val[CW-1:0] = duty_q[i];
    end
    if (word == W_CTRL) begin
      rd_val[PW-1:0]  = pre_q;
      rd_val[RUN_BIT] = run_q;
    end
    if (word == W_IRQ) rd_val[IRQ_BIT] = irq_q;
    if (word == W_CNT) rd_val[CW-1:0]  = cnt;
  end

  assign rdata = rd_en ? rd_val : '0;
  assign run   = run_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int PW  = 4,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);

  // Internal events brought out as named wires for the checker.
  logic                   run_w;
  logic                   tick_w;
  logic                   wrap_w;
  logic                   load_w;
  logic [CW-1:0]          cnt_w;
  logic [PW-1:0]          pre_nxt_w;
  logic [NCH-1:0][CW-1:0] duty_nxt_w;
  logic [NCH-1:0][CW-1:0] act_duty_w;

  // Active copies follow the staged ones while stopped, else only at wrap.
  assign load_w = !run_w || wrap_w;

  pwm_bank_regs #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt_w),
    .rdata    (bus_rdata),
    .duty_nxt (duty_nxt_w),
    .pre_nxt  (pre_nxt_w),
    .run      (run_w)
  );

  pwm_bank_divider #(.PW(PW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .load    (load_w),
    .pre_nxt (pre_nxt_w),
    .tick    (tick_w)
  );

  pwm_bank_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .tick  (tick_w),
    .cnt   (cnt_w),
    .wrap  (wrap_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_bank_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w),
      .load     (load_w),
      .duty_nxt (duty_nxt_w[g]),
      .cnt      (cnt_w),
      .act_duty (act_duty_w[g]),
      .out      (pwm_out[g])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run,
  input logic                   tick,
  input logic                   wrap,
  input logic [CW-1:0]          cnt,
  input logic [NCH-1:0][CW-1:0] act_duty,
  input logic [NCH-1:0]         pwm_out
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out == '0);  // R5

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);  // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(cnt));  // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick |=> cnt == CW'($past(cnt) + 1'b1));  // R2

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wrap |=> $stable(act_duty));  // R6

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt == '0 |-> &pwm_out);  // R3

  for (genvar g = 0; g < NCH; g++) begin : g_full
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      run && act_duty[g] == TOP |-> pwm_out[g]);  // R4
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_w),
  .tick     (tick_w),
  .wrap     (wrap_w),
  .cnt      (cnt_w),
  .act_duty (act_duty_w),
  .pwm_out  (pwm_out)
);

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Reference model state
  int m_run, m_div, m_cnt, m_apre, m_spre, m_irq;
  int m_sh[NCH];
  int m_act[NCH];

  always #5 clk = ~clk;

  pwm_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read();
    int w;
    if (!bus_rd) return 32'h0;
    w = int'(bus_addr) / 4;
    if (w < NCH)  return 32'(m_sh[w]);
    if (w == 20)  return 32'((m_run << 9) | m_spre);
    if (w == 21)  return 32'(m_irq);
    if (w == 24)  return 32'(m_cnt);
    return 32'h0;
  endfunction

  function automatic logic [NCH-1:0] exp_out();
    logic [NCH-1:0] v = '0;
    for (int i = 0; i < NCH; i++) v[i] = (m_run != 0) && (m_cnt <= m_act[i]);
    return v;
  endfunction

  // Model step: period logic uses the state before the edge, then the bus
  // write lands, then the active copies take the freshly written values.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_div = 0; m_cnt = 0; m_apre = 0; m_spre = 0; m_irq = 0;
      for (int i = 0; i < NCH; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    end else begin
      int old_run, w;
      bit tk, wr_now;
      old_run = m_run;
      tk = (old_run != 0) && (m_div == m_apre);
      wr_now = (old_run != 0) && tk && (m_cnt == 255);
      if (old_run == 0) begin m_div = 0; m_cnt = 0; end
      else if (tk) begin m_div = 0; m_cnt = (m_cnt + 1) % 256; end
      else m_div = m_div + 1;
      if (bus_wr) begin
        w = int'(bus_addr) / 4;
        if (w < NCH) m_sh[w] = int'(bus_wdata[7:0]);
        if (w == 20) begin m_spre = int'(bus_wdata[3:0]); m_run = int'(bus_wdata[9]); end
        if (w == 21) m_irq = int'(bus_wdata[0]);
      end
      if (old_run == 0 || wr_now) begin
        m_apre = m_spre;
        for (int i = 0; i < NCH; i++) m_act[i] = m_sh[i];
      end
      #2;
      chk({cur_req, " out"}, 32'(pwm_out), 32'(exp_out()));
      chk({cur_req, " rdata"}, bus_rdata, exp_read());
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic measure(input string req, input int ch, input int len, input int exp);
    int n = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
    chk(req, 32'(n), 32'(exp));
  endtask

  // Put a duty write on the very edge where the counter wraps (prescale 0).
  task automatic write_at_wrap(input logic [7:0] a, input logic [31:0] d);
    bit hit = 0;
    while (!hit) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 8'h60;
      #1;
      if (bus_rdata == 32'd255) hit = 1;
    end
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    chk("R1 outputs", 32'(pwm_out), 32'h0);
    read_expect("R1 ctrl", 8'h50, 32'h0);
    read_expect("R1 counter", 8'h60, 32'h0);
    read_expect("R1 duty1", 8'h04, 32'h0);

    // R7: register map and masking
    cur_req = "R7";
    bus_write(8'h00, 32'hFFFF_FF00);
    bus_write(8'h04, 32'hABCD_1264);
    bus_write(8'h08, 32'h0000_00FF);
    bus_write(8'h0C, 32'h5555_5507);
    bus_write(8'h54, 32'hFFFF_FFFF);
    read_expect("R7 duty0", 8'h00, 32'h0);
    read_expect("R7 duty1", 8'h04, 32'h64);
    read_expect("R7 irq", 8'h54, 32'h1);

    // R9: unmapped addresses
    cur_req = "R9";
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h58, 32'hFFFF_FFFF);
    read_expect("R9 slot4", 8'h10, 32'h0);
    read_expect("R9 0x58", 8'h58, 32'h0);
    read_expect("R9 0xFC", 8'hFC, 32'h0);
    read_expect("R9 duty3 kept", 8'h0C, 32'h07);
    chk("R9 outputs", 32'(pwm_out), 32'h0);

    // R10: no read strobe
    cur_req = "R10";
    @(negedge clk);
    bus_addr = 8'h04;
    #1 chk("R10 rdata idle", bus_rdata, 32'h0);

    // R2/R3/R4 with prescale 2
    cur_req = "R3";
    bus_write(8'h50, 32'h0000_0202);
    read_expect("R7 ctrl", 8'h50, 32'h202);
    repeat (50) @(negedge clk);
    measure("R3 duty 0", 0, 768, 3);
    measure("R3 duty 100", 1, 768, 303);
    measure("R4 duty 255", 2, 768, 768);
    cur_req = "R2";
    measure("R2 duty 7 at prescale 2", 3, 768, 24);

    // R6: staged updates
    cur_req = "R6";
    bus_write(8'h50, 32'h0000_0200);
    bus_write(8'h0C, 32'h0000_00C8);
    read_expect("R6 staged duty3", 8'h0C, 32'hC8);
    repeat (1000) @(negedge clk);
    measure("R6 duty3 after wrap", 3, 256, 201);
    write_at_wrap(8'h04, 32'h0000_000A);
    repeat (20) @(negedge clk);
    measure("R6 write on wrap edge", 1, 256, 11);

    // R8: counter is read-only
    cur_req = "R8";
    bus_write(8'h60, 32'h0000_0055);
    repeat (10) @(negedge clk);
    read_expect("R8 ctrl untouched", 8'h50, 32'h200);

    // R5: stop
    cur_req = "R5";
    bus_write(8'h50, 32'h0000_0000);
    chk("R5 outputs low", 32'(pwm_out), 32'h0);
    read_expect("R5 counter zero", 8'h60, 32'h0);
    repeat (300) @(negedge clk);
    chk("R5 still low", 32'(pwm_out), 32'h0);

    // R6/R2: idle writes apply at once, prescale 5
    cur_req = "R6";
    bus_write(8'h00, 32'h0000_0032);
    bus_write(8'h50, 32'h0000_0205);
    repeat (30) @(negedge clk);
    measure("R2 duty 50 at prescale 5", 0, 1536, 306);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule